// File: doc/BRIEF.md
# Timer Event Output Generator

This block drives a timer's external pin when that pin is used as an output. It takes one-cycle overflow and match strobes from the counter core, together with a trigger mode, a toggle/pulse select, an idle level, a run flag and a pin direction bit. On each qualifying event it either inverts a held output level or emits a pulse that lasts one clock.

When triggering is switched off or the counter is stopped, the pin returns to the programmed idle level. When the pin is configured as an input, the output register freezes. A registered flag reports the illegal combination of an active trigger mode with an input-configured pin. A registered direction output goes to the pad logic.

Top module: `evgen_event_out`

## Requirements
- R1: `trig_mode` is 2 bits wide. 0 means no triggering, 1 means overflow only, 2 means overflow and match. Code 3 is reserved and behaves exactly like 0.
- R2: An overflow strobe qualifies in modes 1 and 2. A match strobe qualifies only in mode 2 and has no effect on `evt_out` in mode 1.
- R3: With `toggle_sel`=1, each qualifying event inverts `evt_out` at the next clock edge. In cycles without an event, the level is held.
- R4: In mode 2, an overflow and a match in the same cycle count as two events. In toggle mode `evt_out` therefore stays unchanged. In pulse mode a single one-cycle pulse results.
- R5: With `toggle_sel`=0, a qualifying event drives `evt_out` to the inverse of `idle_lvl` for exactly one cycle after the next edge. In all other active cycles `evt_out` equals `idle_lvl`.
- R6: When `trig_mode` is 0 or 3, or `running`=0, `evt_out` is loaded with `idle_lvl` at the next edge, and strobes are ignored.
- R7: While `pin_is_input`=1, `evt_out` keeps its value regardless of the other inputs. `pin_oe` equals the inverse of `pin_is_input` from the previous cycle.
- R8: `cfg_err` equals (`pin_is_input`=1 and `trig_mode`!=0) as sampled at the previous edge.
- R9: Synchronous reset `rst` clears `evt_out`, `pin_oe` and `cfg_err` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ovf_stb | input | 1 | Counter overflow strobe, one cycle |
| match_stb | input | 1 | Compare match strobe, one cycle |
| trig_mode | input | 2 | 0 none, 1 overflow, 2 overflow and match, 3 reserved |
| toggle_sel | input | 1 | 1 toggle level, 0 single-cycle pulse |
| idle_lvl | input | 1 | Level held while inactive |
| running | input | 1 | Counter running flag |
| pin_is_input | input | 1 | Pin direction, 1 means input |
| evt_out | output | 1 | Registered pin value |
| pin_oe | output | 1 | Registered output enable for the pad |
| cfg_err | output | 1 | Trigger mode programmed on an input pin |

## Verification
The properties assume that the strobes are sampled only on clock edges and that every control input is stable across an edge. They also assume that a toggle-hold check applies only when exactly one kind of event arrives in mode 1. The bench changes every input on the falling edge and keeps it for a whole cycle, so each input pattern occupies exactly one sampled edge. The bench also sets up a known output level through the idle path before each toggle sequence.

// File: rtl/evgen_pkg.sv
package evgen_pkg;
  typedef enum logic [1:0] {
    TRIG_NONE  = 2'd0,
    TRIG_OVF   = 2'd1,
    TRIG_BOTH  = 2'd2,
    TRIG_RSVD  = 2'd3
  } trig_mode_e;

  localparam int EV_CNT_W = 2;
endpackage

// File: rtl/evgen_qualify.sv
module evgen_qualify
  import evgen_pkg::*;
(
  input  logic                ovf_stb,
  input  logic                match_stb,
  input  logic [1:0]          trig_mode,
  output logic                active,
  output logic [EV_CNT_W-1:0] ev_cnt
);
  logic ovf_q, mat_q;

  always_comb begin
    active = (trig_mode == TRIG_OVF) || (trig_mode == TRIG_BOTH);
    ovf_q  = active && ovf_stb;
    mat_q  = (trig_mode == TRIG_BOTH) && match_stb;
    ev_cnt = EV_CNT_W'(ovf_q) + EV_CNT_W'(mat_q);
  end
endmodule

// File: rtl/evgen_level.sv
module evgen_level
  import evgen_pkg::*;
#(
  parameter logic RESET_LEVEL = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                active,
  input  logic                running,
  input  logic                pin_is_input,
  input  logic                toggle_sel,
  input  logic                idle_lvl,
  input  logic [EV_CNT_W-1:0] ev_cnt,
  output logic                lvl_q
);
  logic nxt;

  always_comb begin
    nxt = lvl_q;
    if (!pin_is_input) begin
      if (!active || !running)
        nxt = idle_lvl;
      else if (toggle_sel)
        nxt = lvl_q ^ ev_cnt[0];
      else
        nxt = (ev_cnt != '0) ? ~idle_lvl : idle_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= RESET_LEVEL;
    else     lvl_q <= nxt;
  end
endmodule

// File: rtl/evgen_cfgchk.sv
module evgen_cfgchk
  import evgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_is_input,
  input  logic [1:0] trig_mode,
  output logic       pin_oe,
  output logic       cfg_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_oe  <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      pin_oe  <= ~pin_is_input;
      cfg_err <= pin_is_input && (trig_mode != TRIG_NONE);
    end
  end
endmodule

// File: rtl/evgen_event_out.sv
module evgen_event_out
  import evgen_pkg::*;
#(
  parameter logic RESET_LEVEL = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ovf_stb,
  input  logic       match_stb,
  input  logic [1:0] trig_mode,
  input  logic       toggle_sel,
  input  logic       idle_lvl,
  input  logic       running,
  input  logic       pin_is_input,
  output logic       evt_out,
  output logic       pin_oe,
  output logic       cfg_err
);
  logic                active;
  logic [EV_CNT_W-1:0] ev_cnt;

  evgen_qualify u_qual (
    .ovf_stb   (ovf_stb),
    .match_stb (match_stb),
    .trig_mode (trig_mode),
    .active    (active),
    .ev_cnt    (ev_cnt)
  );

  evgen_level #(.RESET_LEVEL(RESET_LEVEL)) u_lvl (
    .clk          (clk),
    .rst          (rst),
    .active       (active),
    .running      (running),
    .pin_is_input (pin_is_input),
    .toggle_sel   (toggle_sel),
    .idle_lvl     (idle_lvl),
    .ev_cnt       (ev_cnt),
    .lvl_q        (evt_out)
  );

  evgen_cfgchk u_cfg (
    .clk          (clk),
    .rst          (rst),
    .pin_is_input (pin_is_input),
    .trig_mode    (trig_mode),
    .pin_oe       (pin_oe),
    .cfg_err      (cfg_err)
  );
endmodule

// File: rtl/evgen_event_out_chk.sv
module evgen_event_out_chk (
  input logic       clk,
  input logic       rst,
  input logic       ovf_stb,
  input logic       match_stb,
  input logic [1:0] trig_mode,
  input logic       toggle_sel,
  input logic       idle_lvl,
  input logic       running,
  input logic       pin_is_input,
  input logic       evt_out,
  input logic       pin_oe,
  input logic       cfg_err
);
  // R6 / R1: inactive mode or stopped counter forces idle level
  a_r6_idle_forced: assert property (@(posedge clk) disable iff (rst)
    (!pin_is_input && (!running || trig_mode == 2'd0 || trig_mode == 2'd3))
      |=> (evt_out == $past(idle_lvl)));

  // R7: input direction freezes the pin value
  a_r7_hold_input: assert property (@(posedge clk) disable iff (rst)
    pin_is_input |=> $stable(evt_out));

  // R7: direction output follows the direction bit one cycle later
  a_r7_pin_oe: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pin_oe == !$past(pin_is_input)));

  // R8: configuration error flag
  a_r8_cfg_err: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cfg_err == $past(pin_is_input && trig_mode != 2'd0)));

  // R3: single overflow in mode 1 with toggling inverts the level
  a_r3_toggle: assert property (@(posedge clk) disable iff (rst)
    (!pin_is_input && running && trig_mode == 2'd1 && toggle_sel && ovf_stb)
      |=> (evt_out != $past(evt_out)));

  // R5 / R2: pulse mode without qualifying events sits at idle
  a_r5_pulse_idle: assert property (@(posedge clk) disable iff (rst)
    (!pin_is_input && running && trig_mode == 2'd1 && !toggle_sel && !ovf_stb)
      |=> (evt_out == $past(idle_lvl)));
endmodule

bind evgen_event_out evgen_event_out_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .ovf_stb      (ovf_stb),
  .match_stb    (match_stb),
  .trig_mode    (trig_mode),
  .toggle_sel   (toggle_sel),
  .idle_lvl     (idle_lvl),
  .running      (running),
  .pin_is_input (pin_is_input),
  .evt_out      (evt_out),
  .pin_oe       (pin_oe),
  .cfg_err      (cfg_err)
);

// File: tb/tb_evgen_event_out.sv
module tb_evgen_event_out;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ovf_stb = 1'b0, match_stb = 1'b0;
  logic [1:0] trig_mode = 2'd0;
  logic       toggle_sel = 1'b0, idle_lvl = 1'b0, running = 1'b0;
  logic       pin_is_input = 1'b0;
  logic       evt_out, pin_oe, cfg_err;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  evgen_event_out dut (
    .clk(clk), .rst(rst), .ovf_stb(ovf_stb), .match_stb(match_stb),
    .trig_mode(trig_mode), .toggle_sel(toggle_sel), .idle_lvl(idle_lvl),
    .running(running), .pin_is_input(pin_is_input),
    .evt_out(evt_out), .pin_oe(pin_oe), .cfg_err(cfg_err)
  );

  task automatic chk(string req, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  // set inputs on falling edge, then pass one rising edge and sample
  task automatic step(logic ov, logic ma, logic [1:0] md, logic tg,
                      logic idl, logic run, logic din);
    @(negedge clk);
    ovf_stb = ov; match_stb = ma; trig_mode = md; toggle_sel = tg;
    idle_lvl = idl; running = run; pin_is_input = din;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 evt_out", evt_out, 1'b0);
    chk("R9 pin_oe", pin_oe, 1'b0);
    chk("R9 cfg_err", cfg_err, 1'b0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_idle();
    step(0,0,2'd0,0,1,1,0); chk("R6 mode none idle", evt_out, 1'b1);
    chk("R7 pin_oe on", pin_oe, 1'b1);
    step(1,1,2'd0,0,1,1,0); chk("R6 strobes ignored", evt_out, 1'b1);
    step(1,0,2'd2,0,0,0,0); chk("R6 stopped idle", evt_out, 1'b0);
    step(1,0,2'd3,0,1,1,0); chk("R1 reserved as none", evt_out, 1'b1);
    step(1,0,2'd3,1,0,1,0); chk("R1 reserved toggle idle", evt_out, 1'b0);
  endtask

  task automatic t_pulse();
    step(0,0,2'd1,0,0,1,0); chk("R5 no event idle", evt_out, 1'b0);
    step(1,0,2'd1,0,0,1,0); chk("R5 pulse high", evt_out, 1'b1);
    step(0,0,2'd1,0,0,1,0); chk("R5 pulse one cycle", evt_out, 1'b0);
    step(1,0,2'd1,0,1,1,0); chk("R5 inverted pulse", evt_out, 1'b0);
    step(0,0,2'd1,0,1,1,0); chk("R5 back to idle", evt_out, 1'b1);
    step(0,1,2'd1,0,0,1,0); chk("R2 match ignored mode1", evt_out, 1'b0);
    step(0,1,2'd2,0,0,1,0); chk("R2 match pulses mode2", evt_out, 1'b1);
    step(1,1,2'd2,0,0,1,0); chk("R4 both pulse", evt_out, 1'b1);
    step(0,0,2'd2,0,0,1,0); chk("R4 pulse ends", evt_out, 1'b0);
  endtask

  task automatic t_toggle();
    step(0,0,2'd0,0,0,1,0); chk("R6 preset low", evt_out, 1'b0);
    step(0,0,2'd1,1,0,1,0); chk("R3 hold no event", evt_out, 1'b0);
    step(1,0,2'd1,1,0,1,0); chk("R3 first toggle", evt_out, 1'b1);
    step(0,0,2'd1,1,0,1,0); chk("R3 hold high", evt_out, 1'b1);
    step(0,1,2'd1,1,0,1,0); chk("R2 match no toggle", evt_out, 1'b1);
    step(1,0,2'd1,1,0,1,0); chk("R3 second toggle", evt_out, 1'b0);
    step(0,1,2'd2,1,0,1,0); chk("R3 match toggles mode2", evt_out, 1'b1);
    step(1,1,2'd2,1,0,1,0); chk("R4 both cancel", evt_out, 1'b1);
  endtask

  task automatic t_input();
    step(0,0,2'd0,0,1,1,0); chk("R6 preset high", evt_out, 1'b1);
    step(0,0,2'd0,0,0,1,1); chk("R7 hold on input", evt_out, 1'b1);
    chk("R7 pin_oe off", pin_oe, 1'b0);
    chk("R8 no err mode none", cfg_err, 1'b0);
    step(1,0,2'd1,0,0,1,1); chk("R7 event ignored", evt_out, 1'b1);
    chk("R8 err set", cfg_err, 1'b1);
    step(0,0,2'd0,0,0,1,0); chk("R8 err clears", cfg_err, 1'b0);
    chk("R7 pin_oe back", pin_oe, 1'b1);
    chk("R6 idle after input", evt_out, 1'b0);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_pulse();
    t_toggle();
    t_input();
    t_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule